// File: doc/BRIEF.md
# Cached DRAM Refresh and Start-up Sequencer

This block sits on the controller side of a DRAM with an integrated row cache. After reset it wakes the memory with a burst of row-enable cycles. It then primes the cache logic with dummy reads, two to different rows in each of the four banks. Only then does it raise `ready`.

From then on a free-running interval timer marks when an internal-counter refresh is owed. The sequencer arbitrates that refresh against host row commands. A host asks for a row cycle with `host_req`, giving the kind (`host_we`) and the row. The sequencer answers with a one-clock `host_gnt` at the moment it starts that cycle on the memory lines.

Every row cycle has the same shape: row enable low for `ACT_CYC` clocks, then high for at least `PRE_CYC` clocks. The refresh interval is derived from the clock rate in kHz, the refresh window in milliseconds and the required refresh count per window. With the defaults (50 MHz, 64 ms, 1024 refreshes) it is 3125 clocks.

Top module: `rfs_sequencer`

## Requirements
- R1: While reset is asserted, `mem_re_n` and `mem_rf_n` are 1, and `ready` and `host_gnt` are 0.
- R2: The first eight row cycles after reset are refresh cycles, meaning `mem_rf_n` is 0 while `mem_re_n` is low. `mem_rf_n` is never low while `mem_re_n` is high.
- R3: Cycles 9 to 16 are reads (`mem_wr`=0, `mem_rf_n`=1). Their row address has bank field `mem_addr[9:8]` in the order 0,0,1,1,2,2,3,3. Bit 0 is 0 for the first read of a bank and 1 for the second. All other address bits are 0.
- R4: `ready` rises exactly `ACT_CYC+PRE_CYC+1` clocks after row enable falls for the sixteenth cycle. Once high, it stays high until reset.
- R5: No `host_gnt` is given while `ready` is low, even with `host_req` held high.
- R6: Row enable stays low for exactly `ACT_CYC` clocks per cycle. It is then high for at least `PRE_CYC` clocks before the next fall. Both values are at least 2.
- R7: `host_gnt` is a one-clock pulse in the first clock that row enable is low for the granted cycle. During that cycle `mem_rf_n`=1, `mem_wr` equals `host_we`, and `mem_addr` equals `host_row` and holds steady while row enable is low.
- R8: One refresh becomes owed every `INTERVAL` clocks after reset is released. Each owed refresh begins no later than 7 clocks after it falls due, so a window of three intervals holds exactly three refresh cycles after start-up.
- R9: An owed refresh is taken before any host command not yet started. No host cycle begins between the moment a refresh falls due and the start of that refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host asks for a row cycle |
| host_we | input | 1 | Requested cycle kind: 1 write, 0 read |
| host_row | input | ROW_W | Requested row address |
| host_gnt | output | 1 | One-clock pulse: host cycle started |
| ready | output | 1 | Start-up and priming complete |
| mem_re_n | output | 1 | Row enable toward the memory, active low |
| mem_rf_n | output | 1 | Refresh select toward the memory, active low |
| mem_wr | output | 1 | Write/read select toward the memory |
| mem_addr | output | ROW_W | Row address toward the memory |

## Verification
Two things can fall in the same clock: a refresh coming due and a host request waiting for the engine to go idle. The bench provokes this by keeping the host request asserted continuously for more than three refresh intervals, so every timer expiry lands in the middle of back-to-back host traffic. It judges each refresh against the exact clock its interval ended. The refresh must start within the allowed window, and the cycle before it must have begun no later than that due clock. This shows that no host grant slipped in ahead of it.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        CYC_REFRESH = 2'd0,
        CYC_READ    = 2'd1,
        CYC_WRITE   = 2'd2
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACT  = 2'd1,
        PH_PRE  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEQ_WAKE  = 2'd0,
        SEQ_PRIME = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_e;

endpackage

// File: rtl/rfs_tick_timer.sv
module rfs_tick_timer #(
    parameter int INTERVAL = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == '0) begin
            tmr_d.cnt  = CNT_W'(INTERVAL - 1);
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
            if (ack) begin
                tmr_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt  <= CNT_W'(INTERVAL - 1);
            tmr_q.pend <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pending = tmr_q.pend;
endmodule

// File: rtl/rfs_prime_addr.sv
module rfs_prime_addr #(
    parameter int ROW_W          = 11,
    parameter int BANK_LSB       = 8,
    parameter int BANK_BITS      = 2,
    parameter int PRIME_PER_BANK = 2,
    parameter int STEP_W         = 4
) (
    input  logic [STEP_W-1:0] step,
    output logic [ROW_W-1:0]  row
);
    localparam int PASS_W = (PRIME_PER_BANK > 2) ? $clog2(PRIME_PER_BANK) : 1;

    always_comb begin
        row = '0;
        row[BANK_LSB +: BANK_BITS] = BANK_BITS'(step / PRIME_PER_BANK);
        row[PASS_W-1:0]            = PASS_W'(step % PRIME_PER_BANK);
    end
endmodule

// File: rtl/rfs_row_engine.sv
module rfs_row_engine
    import rfs_pkg::*;
#(
    parameter int ROW_W   = 11,
    parameter int ACT_CYC = 3,
    parameter int PRE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  cyc_kind_e        kind,
    input  logic [ROW_W-1:0] row,
    output logic             idle,
    output logic             re_n,
    output logic             rf_n,
    output logic             wr,
    output logic [ROW_W-1:0] addr
);
    localparam int LONGEST = (ACT_CYC > PRE_CYC) ? ACT_CYC : PRE_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             re_n;
        logic             rf_n;
        logic             wr;
        logic [ROW_W-1:0] addr;
    } eng_t;

    eng_t eng_q, eng_d;

    always_comb begin
        eng_d = eng_q;
        case (eng_q.ph)
            PH_IDLE: begin
                if (start) begin
                    eng_d.ph   = PH_ACT;
                    eng_d.cnt  = CNT_W'(ACT_CYC - 1);
                    eng_d.re_n = 1'b0;
                    eng_d.rf_n = (kind != CYC_REFRESH);
                    eng_d.wr   = (kind == CYC_WRITE);
                    eng_d.addr = (kind == CYC_REFRESH) ? '0 : row;
                end
            end
            PH_ACT: begin
                if (eng_q.cnt == '0) begin
                    eng_d.ph   = PH_PRE;
                    eng_d.cnt  = CNT_W'(PRE_CYC - 1);
                    eng_d.re_n = 1'b1;
                    eng_d.rf_n = 1'b1;
                end else begin
                    eng_d.cnt = eng_q.cnt - 1'b1;
                end
            end
            PH_PRE: begin
                if (eng_q.cnt == '0) begin
                    eng_d.ph = PH_IDLE;
                end else begin
                    eng_d.cnt = eng_q.cnt - 1'b1;
                end
            end
            default: eng_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q.ph   <= PH_IDLE;
            eng_q.cnt  <= '0;
            eng_q.re_n <= 1'b1;
            eng_q.rf_n <= 1'b1;
            eng_q.wr   <= 1'b0;
            eng_q.addr <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign idle = (eng_q.ph == PH_IDLE);
    assign re_n = eng_q.re_n;
    assign rf_n = eng_q.rf_n;
    assign wr   = eng_q.wr;
    assign addr = eng_q.addr;
endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer
    import rfs_pkg::*;
#(
    parameter int CLK_KHZ        = 50000,
    parameter int WINDOW_MS      = 64,
    parameter int REFRESH_COUNT  = 1024,
    parameter int ROW_W          = 11,
    parameter int BANK_LSB       = 8,
    parameter int BANK_BITS      = 2,
    parameter int PRIME_PER_BANK = 2,
    parameter int WAKE_CYCLES    = 8,
    parameter int ACT_CYC        = 3,
    parameter int PRE_CYC        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [ROW_W-1:0] host_row,
    output logic             host_gnt,
    output logic             ready,
    output logic             mem_re_n,
    output logic             mem_rf_n,
    output logic             mem_wr,
    output logic [ROW_W-1:0] mem_addr
);
    localparam int INTERVAL    = (CLK_KHZ * WINDOW_MS) / REFRESH_COUNT;
    localparam int BANKS       = 1 << BANK_BITS;
    localparam int PRIME_TOTAL = BANKS * PRIME_PER_BANK;
    localparam int MAX_STEPS   = (WAKE_CYCLES > PRIME_TOTAL) ? WAKE_CYCLES : PRIME_TOTAL;
    localparam int STEP_W      = $clog2(MAX_STEPS + 1);

    typedef struct packed {
        seq_e              st;
        logic [STEP_W-1:0] step;
        logic              ready;
        logic              gnt;
    } seq_t;

    seq_t seq_q, seq_d;

    logic             eng_idle;
    logic             eng_start;
    cyc_kind_e        eng_kind;
    logic [ROW_W-1:0] eng_row;
    logic [ROW_W-1:0] prime_row;
    logic             ref_pending;
    logic             ref_ack;

    rfs_tick_timer #(
        .INTERVAL(INTERVAL)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    rfs_prime_addr #(
        .ROW_W          (ROW_W),
        .BANK_LSB       (BANK_LSB),
        .BANK_BITS      (BANK_BITS),
        .PRIME_PER_BANK (PRIME_PER_BANK),
        .STEP_W         (STEP_W)
    ) u_prime (
        .step (seq_q.step),
        .row  (prime_row)
    );

    rfs_row_engine #(
        .ROW_W   (ROW_W),
        .ACT_CYC (ACT_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .kind  (eng_kind),
        .row   (eng_row),
        .idle  (eng_idle),
        .re_n  (mem_re_n),
        .rf_n  (mem_rf_n),
        .wr    (mem_wr),
        .addr  (mem_addr)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.gnt = 1'b0;
        eng_start = 1'b0;
        eng_kind  = CYC_REFRESH;
        eng_row   = '0;
        ref_ack   = 1'b0;
        case (seq_q.st)
            SEQ_WAKE: begin
                if (eng_idle) begin
                    eng_start = 1'b1;
                    if (seq_q.step == STEP_W'(WAKE_CYCLES - 1)) begin
                        seq_d.st   = SEQ_PRIME;
                        seq_d.step = '0;
                    end else begin
                        seq_d.step = seq_q.step + 1'b1;
                    end
                end
            end
            SEQ_PRIME: begin
                if (eng_idle) begin
                    eng_start = 1'b1;
                    eng_kind  = CYC_READ;
                    eng_row   = prime_row;
                    if (seq_q.step == STEP_W'(PRIME_TOTAL - 1)) begin
                        seq_d.st   = SEQ_RUN;
                        seq_d.step = '0;
                    end else begin
                        seq_d.step = seq_q.step + 1'b1;
                    end
                end
            end
            SEQ_RUN: begin
                if (!seq_q.ready) begin
                    if (eng_idle) begin
                        seq_d.ready = 1'b1;
                    end
                end else if (eng_idle) begin
                    if (ref_pending) begin
                        eng_start = 1'b1;
                        ref_ack   = 1'b1;
                    end else if (host_req) begin
                        eng_start = 1'b1;
                        eng_kind  = host_we ? CYC_WRITE : CYC_READ;
                        eng_row   = host_row;
                        seq_d.gnt = 1'b1;
                    end
                end
            end
            default: seq_d.st = SEQ_WAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st    <= SEQ_WAKE;
            seq_q.step  <= '0;
            seq_q.ready <= 1'b0;
            seq_q.gnt   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign host_gnt = seq_q.gnt;
    assign ready    = seq_q.ready;
endmodule

// File: rtl/rfs_sequencer_chk.sv
module rfs_sequencer_chk #(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_gnt,
    input logic             ready,
    input logic             mem_re_n,
    input logic             mem_rf_n,
    input logic [ROW_W-1:0] mem_addr
);
    // R5
    no_early_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !host_gnt);

    // R4
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R7
    grant_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> ($fell(mem_re_n) && mem_rf_n));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_re_n && !$past(mem_re_n)) |-> $stable(mem_addr));

    // R2
    refresh_inside_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rf_n |-> !mem_re_n);

    // R6
    min_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_re_n) |=> mem_re_n);

    // R6
    min_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_re_n) |=> !mem_re_n);
endmodule

bind rfs_sequencer rfs_sequencer_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/tb_rfs_sequencer.sv
module tb_rfs_sequencer;
    localparam int ROW_W    = 11;
    localparam int ACT      = 3;
    localparam int PRE      = 2;
    localparam int INTERVAL = (50000 * 64) / 1024;
    localparam int MAXREC   = 4096;

    localparam logic [11:0] VEC [0:7] = '{
        12'hFFF, 12'h000, 12'h8A5, 12'h3C3,
        12'h900, 12'h1FF, 12'hC00, 12'h655
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0;
    logic host_we = 1'b0;
    logic [ROW_W-1:0] host_row = '0;
    logic host_gnt, ready, mem_re_n, mem_rf_n, mem_wr;
    logic [ROW_W-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic             rec_rf   [MAXREC];
    logic             rec_wr   [MAXREC];
    logic             rec_gnt  [MAXREC];
    logic [ROW_W-1:0] rec_addr [MAXREC];
    int               rec_t    [MAXREC];
    int rec_n = 0;
    int act_viol = 0, gap_viol = 0, addr_viol = 0, gnt_early = 0, ready_drop = 0;
    int fall_t = 0, last_rise = 0, ready_t = -1;
    bit ready_seen = 1'b0;
    logic prev_re = 1'b1;
    logic [ROW_W-1:0] prev_addr = '0;

    rfs_sequencer dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_row(host_row), .host_gnt(host_gnt), .ready(ready),
        .mem_re_n(mem_re_n), .mem_rf_n(mem_rf_n), .mem_wr(mem_wr), .mem_addr(mem_addr)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_re && !mem_re_n) begin
                if (rec_n > 0 && (cyc - last_rise) < PRE) gap_viol++;
                if (rec_n < MAXREC) begin
                    rec_rf[rec_n] = mem_rf_n;  rec_wr[rec_n] = mem_wr;
                    rec_gnt[rec_n] = host_gnt; rec_addr[rec_n] = mem_addr;
                    rec_t[rec_n] = cyc;
                    rec_n++;
                end
                fall_t = cyc;
            end
            if (!prev_re && mem_re_n) begin
                if ((cyc - fall_t) != ACT) act_viol++;
                last_rise = cyc;
            end
            if (!prev_re && !mem_re_n && mem_addr != prev_addr) addr_viol++;
            if (host_gnt && !ready) gnt_early++;
            if (ready_seen && !ready) ready_drop++;
            if (ready && !ready_seen) begin ready_seen = 1'b1; ready_t = cyc; end
            prev_re = mem_re_n;
            prev_addr = mem_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_gnt();
        do begin @(negedge clk); #1; end while (!host_gnt);
    endtask

    task automatic check_last_host(input logic we, input logic [ROW_W-1:0] row);
        int j;
        j = rec_n - 1;
        check(rec_gnt[j] == 1'b1, "R7 grant marks cycle", int'(rec_gnt[j]), 1);
        check(rec_rf[j] == 1'b1, "R7 no refresh", int'(rec_rf[j]), 1);
        check(rec_wr[j] == we, "R7 write select", int'(rec_wr[j]), int'(we));
        check(rec_addr[j] == row, "R7 row address", int'(rec_addr[j]), int'(row));
    endtask

    always @(posedge clk) begin
        if (cyc > 40000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 40000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int nref;
        host_req = 1'b1; host_we = 1'b1; host_row = 11'h155;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_re_n == 1'b1, "R1 row enable idle", int'(mem_re_n), 1);
        check(mem_rf_n == 1'b1, "R1 refresh idle", int'(mem_rf_n), 1);
        check(ready == 1'b0, "R1 ready low", int'(ready), 0);
        check(host_gnt == 1'b0, "R1 no grant", int'(host_gnt), 0);
        rst_n = 1'b1;

        do begin @(negedge clk); #1; end while (!ready);

        check(rec_n == 16, "R3 cycles before ready", rec_n, 16);
        for (int i = 0; i < 8; i++) begin
            // R2 wake-up refresh cycles
            check(rec_rf[i] == 1'b0, "R2 wake cycle is refresh", int'(rec_rf[i]), 0);
        end
        for (int i = 0; i < 8; i++) begin
            logic [ROW_W-1:0] exp_row;
            exp_row = '0;
            exp_row[9:8] = 2'(i / 2);
            exp_row[0] = 1'(i % 2);
            check(rec_rf[8+i] == 1'b1 && rec_wr[8+i] == 1'b0, "R3 priming is read",
                  int'({rec_rf[8+i], rec_wr[8+i]}), 2);
            check(rec_addr[8+i] == exp_row, "R3 priming row", int'(rec_addr[8+i]), int'(exp_row));
        end
        check(ready_t - rec_t[15] == ACT + PRE + 1, "R4 ready timing",
              ready_t - rec_t[15], ACT + PRE + 1);
        // R5: request held through start-up drew no grant
        check(gnt_early == 0, "R5 no grant before ready", gnt_early, 0);

        wait_gnt();
        check_last_host(1'b1, 11'h155);

        for (int v = 0; v < 8; v++) begin
            host_we = VEC[v][11]; host_row = VEC[v][10:0];
            wait_gnt();
            check_last_host(VEC[v][11], VEC[v][10:0]);
        end

        // R9 / R8: back-to-back host traffic across three refresh intervals
        for (int v = 0; cyc < 3 * INTERVAL + 20; v++) begin
            host_we = VEC[v % 8][11]; host_row = VEC[v % 8][10:0];
            wait_gnt();
            check_last_host(VEC[v % 8][11], VEC[v % 8][10:0]);
        end
        host_req = 1'b0;
        repeat (20) @(negedge clk);
        #1;

        nref = 0;
        for (int j = 16; j < rec_n; j++) begin
            if (rec_rf[j] == 1'b0) begin
                int k, delta;
                nref++;
                k = (rec_t[j] - 1) / INTERVAL;
                delta = rec_t[j] - k * INTERVAL;
                check(k >= 1 && delta >= 1 && delta <= 7, "R8 refresh latency", delta, 1);
                check(rec_t[j-1] <= k * INTERVAL, "R9 refresh beats host",
                      rec_t[j-1], k * INTERVAL);
                check(rec_gnt[j] == 1'b0, "R9 refresh not granted", int'(rec_gnt[j]), 0);
            end
        end
        check(nref == 3, "R8 refresh count", nref, 3);
        check(act_viol == 0, "R6 active length", act_viol, 0);
        check(gap_viol == 0, "R6 precharge length", gap_viol, 0);
        check(addr_viol == 0, "R7 address stable", addr_viol, 0);
        check(ready_drop == 0, "R4 ready sticky", ready_drop, 0);
        check(mem_re_n == 1'b1, "R5 idle without request", int'(mem_re_n), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule